// File: doc/BRIEF.md
# USART Configuration Register Bank with Shared Address

This block holds the configuration and status bytes of a serial port and presents them on a small synchronous I/O bus. The bus has an address, write data, a write strobe, a read strobe and a read-data return. Every register is also driven out as a port so that the serial datapath can use the values directly.

Two registers have no address of their own and share one. These are the upper bits of the baud divisor and the frame-control byte. On a write, the top bit of the data chooses the target. On a read, the target depends on recent history. A lone read returns the divisor bits. A read that comes directly after another read of the same location returns the frame-control byte. Software therefore fetches the control byte with two reads in a row. The status byte and the low divisor byte each sit at their own address. Every register leaves reset with a fixed value.

Top module: `usart_cfg_bank`

## Requirements
- R1: After reset, status_o is 0x20, baud_lo_o is 0x0, baud_hi_o is 0x0 and ctrl_o is 0x82.
- R2: A write to the shared address (0x20) with wdata_i[7]=0 loads wdata_i[3:0] into baud_hi_o at the next clock edge and leaves ctrl_o unchanged.
- R3: A write to the shared address with wdata_i[7]=1 loads wdata_i[6:0] into ctrl_o[6:0] at the next clock edge and leaves baud_hi_o unchanged.
- R4: A read of the shared address returns {4'b0, baud_hi_o} when the previous cycle was not a write-free read of the shared address.
- R5: A read of the shared address returns ctrl_o when the previous cycle was a read of the shared address without a write. Three back-to-back reads return divisor, control, control.
- R6: A write to the shared address, or a read of any other address, breaks the read sequence, so the next read of the shared address returns the divisor bits.
- R7: ctrl_o[7] and the bit 7 read back from the control byte are always 1. Bits 7:4 read back from the divisor byte are always 0.
- R8: The status (0x0B) and low-divisor (0x09) addresses store all 8 written bits at the next edge and read back their current value in the same cycle.
- R9: rdata_o is 0 when rd_en_i is low or the address is unmapped, and writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Bus address |
| wdata_i | input | 8 | Bus write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational |
| status_o | output | 8 | Status byte |
| baud_lo_o | output | 8 | Low divisor byte |
| baud_hi_o | output | 4 | High divisor bits |
| ctrl_o | output | 8 | Frame-control byte |

## Verification
The hardest case to reach is a read of the shared address whose result depends on what the bus did in the cycle before. This covers a second and third read held back to back, a read right after a write, and a read right after a read of a different address. The bench keeps the read strobe asserted across clock edges to build each of these histories. It also inserts a single intervening write or foreign-address read to break the sequence. It then compares each read result against the expected register contents.

// File: rtl/usart_cfg_pkg.sv
package usart_cfg_pkg;
    localparam int BYTE_W  = 8;
    localparam int SEL_BIT = BYTE_W - 1;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_STATUS,
        SRC_BAUD_LO,
        SRC_SHARED
    } rd_src_e;
endpackage

// File: rtl/usart_byte_reg.sv
module usart_byte_reg #(
    parameter int           WIDTH = 8,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (we_i) val_d = d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RST_VAL;
        else        val_q <= val_d;
    end

    assign q_o = val_q;
endmodule

// File: rtl/usart_shared_pair.sv
module usart_shared_pair
    import usart_cfg_pkg::*;
#(
    parameter int BHI_W = 4,
    parameter logic [SEL_BIT-1:0] CTRL_RST = 7'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_wr_i,
    input  logic              hit_rd_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BHI_W-1:0]  bhi_o,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0] rd_value_o
);
    typedef struct packed {
        logic [BHI_W-1:0]   bhi;
        logic [SEL_BIT-1:0] ctrl;
        logic               seq;
    } pair_t;

    pair_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit_wr_i) begin
            if (wdata_i[SEL_BIT]) st_d.ctrl = wdata_i[SEL_BIT-1:0];
            else                  st_d.bhi  = wdata_i[BHI_W-1:0];
        end
        // a write-free read of this location arms the second-read path
        st_d.seq = hit_rd_i && !hit_wr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bhi  <= '0;
            st_q.ctrl <= CTRL_RST;
            st_q.seq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bhi_o      = st_q.bhi;
    assign ctrl_o     = {1'b1, st_q.ctrl};
    assign rd_value_o = st_q.seq ? {1'b1, st_q.ctrl}
                                 : {{(BYTE_W-BHI_W){1'b0}}, st_q.bhi};
endmodule

// File: rtl/usart_cfg_bank.sv
module usart_cfg_bank
    import usart_cfg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BHI_W  = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR  = 6'h0B,
    parameter logic [ADDR_W-1:0] BAUD_LO_ADDR = 6'h09,
    parameter logic [ADDR_W-1:0] SHARED_ADDR  = 6'h20,
    parameter logic [BYTE_W-1:0] STATUS_RST   = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic [BYTE_W-1:0] status_o,
    output logic [BYTE_W-1:0] baud_lo_o,
    output logic [BHI_W-1:0]  baud_hi_o,
    output logic [BYTE_W-1:0] ctrl_o
);
    rd_src_e           src;
    logic              hit_status, hit_blo, hit_shared;
    logic [BYTE_W-1:0] shared_val;

    always_comb begin
        hit_status = (addr_i == STATUS_ADDR);
        hit_blo    = (addr_i == BAUD_LO_ADDR);
        hit_shared = (addr_i == SHARED_ADDR);
        if (hit_status)      src = SRC_STATUS;
        else if (hit_blo)    src = SRC_BAUD_LO;
        else if (hit_shared) src = SRC_SHARED;
        else                 src = SRC_NONE;
    end

    usart_byte_reg #(.WIDTH(BYTE_W), .RST_VAL(STATUS_RST)) u_status (
        .clk(clk), .rst_n(rst_n), .we_i(wr_en_i && hit_status),
        .d_i(wdata_i), .q_o(status_o)
    );

    usart_byte_reg #(.WIDTH(BYTE_W), .RST_VAL('0)) u_baud_lo (
        .clk(clk), .rst_n(rst_n), .we_i(wr_en_i && hit_blo),
        .d_i(wdata_i), .q_o(baud_lo_o)
    );

    usart_shared_pair #(.BHI_W(BHI_W), .CTRL_RST(7'h02)) u_pair (
        .clk(clk), .rst_n(rst_n),
        .hit_wr_i(wr_en_i && hit_shared),
        .hit_rd_i(rd_en_i && hit_shared),
        .wdata_i(wdata_i),
        .bhi_o(baud_hi_o),
        .ctrl_o(ctrl_o),
        .rd_value_o(shared_val)
    );

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (src)
                SRC_STATUS:  rdata_o = status_o;
                SRC_BAUD_LO: rdata_o = baud_lo_o;
                SRC_SHARED:  rdata_o = shared_val;
                default:     rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/usart_cfg_bank_chk.sv
module usart_cfg_bank_chk #(
    parameter int ADDR_W = 6,
    parameter int BHI_W  = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 6'h0B,
    parameter logic [ADDR_W-1:0] SHARED_ADDR = 6'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic [7:0]        wdata_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [7:0]        rdata_o,
    input logic [7:0]        status_o,
    input logic [7:0]        baud_lo_o,
    input logic [BHI_W-1:0]  baud_hi_o,
    input logic [7:0]        ctrl_o
);
    logic sh_wr, sh_rd_clean;
    assign sh_wr       = wr_en_i && addr_i == SHARED_ADDR;
    assign sh_rd_clean = rd_en_i && !wr_en_i && addr_i == SHARED_ADDR;

    assert_reset_vals_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status_o == 8'h20 && baud_lo_o == 8'h00 &&
                          baud_hi_o == '0 && ctrl_o == 8'h82));

    assert_bhi_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_wr && !wdata_i[7]) |=>
            (baud_hi_o == $past(wdata_i[BHI_W-1:0]) && $stable(ctrl_o)));

    assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_wr && wdata_i[7]) |=>
            (ctrl_o[6:0] == $past(wdata_i[6:0]) && $stable(baud_hi_o)));

    assert_first_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == SHARED_ADDR && !$past(sh_rd_clean)) |->
            (rdata_o == {{(8-BHI_W){1'b0}}, baud_hi_o}));

    assert_second_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == SHARED_ADDR && $past(sh_rd_clean)) |->
            (rdata_o == ctrl_o && rdata_o[7]));

    assert_status_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == STATUS_ADDR) |=> (status_o == $past(wdata_i)));

    assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |-> (rdata_o == 8'h00));
endmodule

bind usart_cfg_bank usart_cfg_bank_chk #(
    .ADDR_W(ADDR_W), .BHI_W(BHI_W),
    .STATUS_ADDR(STATUS_ADDR), .SHARED_ADDR(SHARED_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
    .status_o(status_o), .baud_lo_o(baud_lo_o), .baud_hi_o(baud_hi_o),
    .ctrl_o(ctrl_o)
);

// File: tb/usart_cfg_bank_test.sv
module usart_cfg_bank_test;
    localparam logic [5:0] A_STAT = 6'h0B;
    localparam logic [5:0] A_BLO  = 6'h09;
    localparam logic [5:0] A_SH   = 6'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rdata, status, blo, ctrl;
    logic [3:0] bhi;

    int n_run = 0, n_fail = 0;
    logic [7:0] e_stat = 8'h20, e_blo = 8'h00, e_ctrl = 8'h82;
    logic [3:0] e_bhi = 4'h0;

    always #2.5 clk = ~clk;

    usart_cfg_bank uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata),
        .status_o(status), .baud_lo_o(blo), .baud_hi_o(bhi), .ctrl_o(ctrl)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk(req, status, e_stat);
        chk(req, blo, e_blo);
        chk(req, {4'h0, bhi}, {4'h0, e_bhi});
        chk(req, ctrl, e_ctrl);
    endtask

    // one bus cycle; combinational rdata checked before the edge
    task automatic bus(input logic w, input logic r, input logic [5:0] a,
                       input logic [7:0] d, input string req, input logic [7:0] exp_rd);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        if (r) chk(req, rdata, exp_rd);
        @(posedge clk); #1;
    endtask

    task automatic idle();
        bus(1'b0, 1'b0, 6'h00, 8'h00, "R9", 8'h00);
    endtask

    task automatic wr_shared(input logic [7:0] v);
        bus(1'b1, 1'b0, A_SH, v, "", 8'h00);
        if (v[7]) e_ctrl = {1'b1, v[6:0]};
        else      e_bhi  = v[3:0];
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst_n = 1'b1;
        #1;
        chk_regs("R1");
        chk("R9", rdata, 8'h00);

        // R4: first read after reset returns divisor, R5 second returns control
        bus(1'b0, 1'b1, A_SH, 8'h00, "R4", 8'h00);
        bus(1'b0, 1'b1, A_SH, 8'h00, "R5", 8'h82);
        idle();

        // R2/R3/R7: sweep all write values to the shared address
        for (int v = 0; v < 256; v++) begin
            wr_shared(v[7:0]);
            chk_regs(v[7] ? "R3" : "R2");
            // R6: read right after write gives divisor; R4/R5/R7 sequence
            bus(1'b0, 1'b1, A_SH, 8'h00, "R6", {4'h0, e_bhi});
            bus(1'b0, 1'b1, A_SH, 8'h00, "R5", e_ctrl);
            bus(1'b0, 1'b1, A_SH, 8'h00, "R5", e_ctrl);
            chk("R7", ctrl & 8'h80, 8'h80);
            idle();
        end

        // R6: a foreign read breaks the sequence
        wr_shared(8'h05);
        wr_shared(8'hA3);
        bus(1'b0, 1'b1, A_SH, 8'h00, "R4", 8'h05);
        bus(1'b0, 1'b1, A_BLO, 8'h00, "R8", e_blo);
        bus(1'b0, 1'b1, A_SH, 8'h00, "R6", 8'h05);
        bus(1'b0, 1'b1, A_SH, 8'h00, "R5", 8'hA3);
        // R6: write to shared in the middle of a read chain
        bus(1'b1, 1'b1, A_SH, 8'h0C, "R5", 8'hA3);
        e_bhi = 4'hC;
        bus(1'b0, 1'b1, A_SH, 8'h00, "R6", 8'h0C);
        bus(1'b0, 1'b1, A_SH, 8'h00, "R5", 8'hA3);
        idle();
        // R4: gap of one idle cycle returns divisor again
        bus(1'b0, 1'b1, A_SH, 8'h00, "R4", 8'h0C);
        idle();

        // R8: plain registers
        for (int v = 0; v < 256; v += 17) begin
            bus(1'b1, 1'b0, A_STAT, v[7:0], "", 8'h00);
            e_stat = v[7:0];
            bus(1'b1, 1'b1, A_BLO, ~v[7:0], "R8", e_blo);
            e_blo = ~v[7:0];
            chk_regs("R8");
            bus(1'b0, 1'b1, A_STAT, 8'h00, "R8", e_stat);
            bus(1'b0, 1'b1, A_BLO, 8'h00, "R8", e_blo);
        end

        // R9: unmapped addresses read 0 and writes change nothing
        for (int a = 0; a < 64; a++) begin
            if (a[5:0] != A_STAT && a[5:0] != A_BLO && a[5:0] != A_SH) begin
                bus(1'b1, 1'b1, a[5:0], 8'hFF, "R9", 8'h00);
                chk_regs("R9");
            end
        end
        wr_en = 1'b0; rd_en = 1'b0; addr = A_STAT; #1;
        chk("R9", rdata, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule